// File: doc/BRIEF.md
# Serial Receiver with Two-Byte Queue

This block receives asynchronous serial frames and turns them into bytes. An outside baud generator supplies a one-cycle sampling strobe per bit period. On each strobe the receiver samples the line. A low level seen while idle starts a frame. The frame then carries eight data bits with the least significant bit first, an optional parity bit and a stop bit. Completed bytes go into a two-entry first-in first-out queue, and a read strobe takes them out oldest first.

Two flags report how full the queue is: one for data present and one for the second byte. When the queue is full, one further completed byte can wait in a holding stage. That byte moves into the queue on the clock after a read frees a slot. If a fourth byte completes while the holding stage is still occupied, it replaces the waiting byte and the overrun flag goes high. The parity, framing and overrun flags stay set until software clears them with a per-bit write-one-to-clear strobe.

Top module: `serial_rx_queue`

## Requirements
- R1: While `rx_en` is 0, the line is ignored. No frame starts, and the flags and queue do not change.
- R2: A frame starts when the idle receiver samples `rxd` low on a strobe (`samp_tick`=1). The next eight strobes each sample one data bit.
- R3: The first data bit sampled becomes bit 0 of the byte. Later bits fill towards bit 7 (LSB first).
- R4: With `par_en`=1, the strobe after bit 7 samples a parity bit. `par_odd`=0 selects even parity and 1 selects odd parity. A mismatch sets `par_err` when the byte enters the queue.
- R5: The strobe after the last data or parity bit samples the stop bit. A low stop bit sets `frm_err`.
- R6: The queue holds two bytes in arrival order. A `rd_stb` pulse on a non-empty queue removes the oldest byte, and that byte appears on `rd_data` in the next cycle.
- R7: `rdy_flag` is 1 when the queue holds one or two bytes. `full_flag` is 1 only when it holds two.
- R8: A `rd_stb` pulse on an empty queue leaves both flags at 0.
- R9: When the queue is full, a third completed byte is held. It enters the queue on the clock after a read frees a slot.
- R10: A byte completing while a held byte is still waiting replaces the held byte and sets `ovr_err`.
- R11: The error flags are sticky. `err_clr` bit 0 clears `par_err`, bit 1 clears `frm_err` and bit 2 clears `ovr_err`.
- R12: Synchronous reset `rst` empties the queue, drops the held byte, clears all flags and returns the receiver to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| samp_tick | input | 1 | One-cycle strobe per bit period |
| rxd | input | 1 | Serial data line, idle high |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| rd_stb | input | 1 | Read strobe, pops the oldest byte |
| err_clr | input | 3 | Write-one-to-clear: [0] parity, [1] framing, [2] overrun |
| rd_data | output | 8 | Byte from the last read |
| rdy_flag | output | 1 | Queue not empty |
| full_flag | output | 1 | Queue holds two bytes |
| par_err | output | 1 | Sticky parity error |
| frm_err | output | 1 | Sticky framing error |
| ovr_err | output | 1 | Sticky overrun error |

## Verification
A wrong queue pointer or count shows up at the first read after the fault. Either `rd_data` carries a byte out of order, or the two flags disagree with the number of frames sent. A broken holding stage shows on the first read at full: `full_flag` fails to come back one cycle later, or the wrong byte comes out third. A wrong bit counter or wrong shift direction corrupts every byte of the next frame. Parity and framing mistakes show as sticky flags present or absent right after the frame that caused them.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_DATA = 2'd1,
    RX_PAR  = 2'd2,
    RX_STOP = 2'd3
  } rx_state_t;
endpackage

// File: rtl/rx_frame.sv
module rx_frame #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              done,
  output logic [DATA_W-1:0] byte_o,
  output logic              par_bad,
  output logic              stop_bad
);
  import serial_rx_pkg::*;
  localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  rx_state_t   st;
  logic [CW-1:0] cnt;
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] sh_next;

  assign sh_next = {rxd, sh[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    done     <= 1'b0;
    stop_bad <= 1'b0;
    if (rst || !en) begin
      st      <= RX_IDLE;
      cnt     <= '0;
      par_bad <= 1'b0;
    end else if (tick) begin
      unique case (st)
        RX_IDLE: if (!rxd) begin
          st  <= RX_DATA;
          cnt <= '0;
        end
        RX_DATA: begin
          sh  <= sh_next;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(DATA_W - 1)) begin
            if (par_en) st <= RX_PAR;
            else begin
              st      <= RX_STOP;
              done    <= 1'b1;
              byte_o  <= sh_next;
              par_bad <= 1'b0;
            end
          end
        end
        RX_PAR: begin
          st      <= RX_STOP;
          done    <= 1'b1;
          byte_o  <= sh;
          par_bad <= (^sh) ^ rxd ^ par_odd;
        end
        RX_STOP: begin
          st       <= RX_IDLE;
          stop_bad <= !rxd;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  p_idle_when_off_r1: assert property (@(posedge clk) disable iff (rst)
    !en |=> (st == RX_IDLE && !done));
  p_done_needs_tick_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(tick));
endmodule

// File: rtl/rx_fifo2.sv
module rx_fifo2 #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              rd_req,
  output logic [DATA_W-1:0] dout,
  output logic              not_empty,
  output logic              full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [NW-1:0] num;
  logic pop;

  assign pop       = rd_req && (num != '0);
  assign not_empty = (num != '0);
  assign full      = (num == NW'(DEPTH));

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (pop) dout <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      num <= '0;
    end else begin
      if (push) wp <= inc(wp);
      if (pop)  rp <= inc(rp);
      if (push && !pop)      num <= num + 1'b1;
      else if (pop && !push) num <= num - 1'b1;
    end
  end

  p_no_push_full_r6: assert property (@(posedge clk) disable iff (rst)
    push |-> (!full || pop));
  p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
    num <= NW'(DEPTH));
  p_empty_read_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !not_empty && !push) |=> !not_empty);
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              samp_tick,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rd_stb,
  input  logic [2:0]        err_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rdy_flag,
  output logic              full_flag,
  output logic              par_err,
  output logic              frm_err,
  output logic              ovr_err
);
  logic              f_done, f_pbad, f_sbad;
  logic [DATA_W-1:0] f_byte;
  logic              held_v, held_bad;
  logic [DATA_W-1:0] held_d;
  logic              drain, push, push_bad, to_held;
  logic [DATA_W-1:0] push_d;

  rx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst), .en(rx_en), .tick(samp_tick), .rxd(rxd),
    .par_en(par_en), .par_odd(par_odd), .done(f_done), .byte_o(f_byte),
    .par_bad(f_pbad), .stop_bad(f_sbad)
  );

  rx_fifo2 #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .din(push_d), .rd_req(rd_stb),
    .dout(rd_data), .not_empty(rdy_flag), .full(full_flag)
  );

  assign drain    = held_v && !full_flag;
  assign to_held  = f_done && (held_v || full_flag);
  assign push     = drain || (f_done && !held_v && !full_flag);
  assign push_d   = drain ? held_d : f_byte;
  assign push_bad = drain ? held_bad : f_pbad;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_v  <= 1'b0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
      ovr_err <= 1'b0;
    end else begin
      if (to_held) begin
        held_v   <= 1'b1;
        held_d   <= f_byte;
        held_bad <= f_pbad;
      end else if (drain) begin
        held_v <= 1'b0;
      end
      par_err <= (par_err && !err_clr[0]) || (push && push_bad);
      frm_err <= (frm_err && !err_clr[1]) || f_sbad;
      ovr_err <= (ovr_err && !err_clr[2]) || (to_held && held_v && !drain);
    end
  end

  p_full_has_rdy_r7: assert property (@(posedge clk) disable iff (rst)
    full_flag |-> rdy_flag);
  p_held_needs_data_r9: assert property (@(posedge clk) disable iff (rst)
    held_v |-> rdy_flag);
  p_ovr_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (ovr_err && !err_clr[2]) |=> ovr_err);
  p_ovr_cause_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_err) |-> $past(held_v && f_done));
endmodule

// File: tb/serial_rx_queue_tb.sv
module serial_rx_queue_tb;
  logic clk = 0, rst = 1, rx_en = 0, samp_tick = 0, rxd = 1;
  logic par_en = 0, par_odd = 0, rd_stb = 0;
  logic [2:0] err_clr = '0;
  logic [7:0] rd_data;
  logic rdy_flag, full_flag, par_err, frm_err, ovr_err;
  int n_run = 0, n_fail = 0;
  logic [7:0] exp_q [$];

  always #5 clk = ~clk;

  serial_rx_queue u_dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .samp_tick(samp_tick), .rxd(rxd),
    .par_en(par_en), .par_odd(par_odd), .rd_stb(rd_stb), .err_clr(err_clr),
    .rd_data(rd_data), .rdy_flag(rdy_flag), .full_flag(full_flag),
    .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err)
  );

  int tcnt = 0;
  always @(posedge clk) begin
    tcnt      <= (tcnt == 3) ? 0 : tcnt + 1;
    samp_tick <= (tcnt == 3);
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    rxd = b;
    while (!samp_tick) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic pbad, input logic stop);
    logic p;
    p = (^d) ^ par_odd ^ pbad;
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    if (par_en) send_bit(p);
    send_bit(stop);
    @(negedge clk);
    rxd = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic read_chk(input string tag);
    logic [7:0] e;
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    e = exp_q.pop_front();
    chk(rd_data == e, tag, rd_data, e);
  endtask

  task automatic clr_all();
    @(negedge clk);
    err_clr = 3'b111;
    @(negedge clk);
    err_clr = 3'b000;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk({rdy_flag, full_flag, par_err, frm_err, ovr_err} == 5'b0, "R12 reset flags",
        {rdy_flag, full_flag, par_err, frm_err, ovr_err}, 0);

    // R1 disabled: frame ignored
    send_frame(8'h5A, 0, 1);
    chk(rdy_flag == 0, "R1 disabled ignores line", rdy_flag, 0);
    rx_en = 1;
    repeat (4) @(negedge clk);

    // R2 R3 single frame, LSB first
    send_frame(8'h01, 0, 1); exp_q.push_back(8'h01);
    chk(rdy_flag == 1 && full_flag == 0, "R7 one byte flags", {rdy_flag, full_flag}, 2'b10);
    read_chk("R3 LSB-first byte");
    chk(rdy_flag == 0, "R7 empty after read", rdy_flag, 0);

    // R8 empty read
    read_chk_empty();

    // R6 two bytes in order
    send_frame(8'hC3, 0, 1); exp_q.push_back(8'hC3);
    send_frame(8'h3C, 0, 1); exp_q.push_back(8'h3C);
    chk(full_flag == 1 && rdy_flag == 1, "R7 two bytes flags", {rdy_flag, full_flag}, 2'b11);
    read_chk("R6 oldest first");
    chk(full_flag == 0 && rdy_flag == 1, "R7 one left", {rdy_flag, full_flag}, 2'b10);
    read_chk("R6 second byte");

    // R9 third byte held
    send_frame(8'h11, 0, 1); exp_q.push_back(8'h11);
    send_frame(8'h22, 0, 1); exp_q.push_back(8'h22);
    send_frame(8'h33, 0, 1); exp_q.push_back(8'h33);
    chk(ovr_err == 0, "R9 no overrun on third", ovr_err, 0);
    read_chk("R9 first of three");
    @(negedge clk);
    chk(full_flag == 1, "R9 held byte refills queue", full_flag, 1);
    read_chk("R9 second of three");
    read_chk("R9 held byte out third");
    chk(rdy_flag == 0, "R9 drained", rdy_flag, 0);

    // R10 overrun
    send_frame(8'hA1, 0, 1); exp_q.push_back(8'hA1);
    send_frame(8'hA2, 0, 1); exp_q.push_back(8'hA2);
    send_frame(8'hA3, 0, 1);
    send_frame(8'hA4, 0, 1); exp_q.push_back(8'hA4);
    chk(ovr_err == 1, "R10 overrun flag", ovr_err, 1);
    read_chk("R10 first");
    read_chk("R10 second");
    read_chk("R10 newest replaced held");
    // R11 sticky then clear
    chk(ovr_err == 1, "R11 overrun sticky", ovr_err, 1);
    @(negedge clk); err_clr = 3'b100; @(negedge clk); err_clr = 3'b000;
    chk(ovr_err == 0, "R11 overrun cleared", ovr_err, 0);

    // R4 parity even good/bad, odd good/bad
    par_en = 1; par_odd = 0;
    send_frame(8'h07, 0, 1); exp_q.push_back(8'h07);
    chk(par_err == 0, "R4 even parity good", par_err, 0);
    read_chk("R4 byte with parity");
    send_frame(8'h07, 1, 1); exp_q.push_back(8'h07);
    chk(par_err == 1, "R4 even parity bad", par_err, 1);
    read_chk("R4 byte bad parity");
    @(negedge clk); err_clr = 3'b001; @(negedge clk); err_clr = 3'b000;
    chk(par_err == 0, "R11 parity cleared", par_err, 0);
    par_odd = 1;
    send_frame(8'h96, 0, 1); exp_q.push_back(8'h96);
    chk(par_err == 0, "R4 odd parity good", par_err, 0);
    read_chk("R4 odd byte");
    send_frame(8'h96, 1, 1); exp_q.push_back(8'h96);
    chk(par_err == 1, "R4 odd parity bad", par_err, 1);
    read_chk("R4 odd bad byte");
    clr_all();
    par_en = 0; par_odd = 0;

    // R5 framing error
    send_frame(8'hE5, 0, 0); exp_q.push_back(8'hE5);
    chk(frm_err == 1, "R5 low stop bit", frm_err, 1);
    chk(par_err == 0 && ovr_err == 0, "R11 other flags untouched", {par_err, ovr_err}, 0);
    read_chk("R5 byte kept");
    @(negedge clk); err_clr = 3'b010; @(negedge clk); err_clr = 3'b000;
    chk(frm_err == 0, "R11 framing cleared", frm_err, 0);

    // R12 reset empties queue
    send_frame(8'h44, 0, 0);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0; @(negedge clk);
    chk({rdy_flag, frm_err} == 2'b00, "R12 reset clears queue and flags", {rdy_flag, frm_err}, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic read_chk_empty();
    @(negedge clk); rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0;
    chk(rdy_flag == 0 && full_flag == 0, "R8 empty read flags", {rdy_flag, full_flag}, 0);
  endtask
endmodule